// File: doc/BRIEF.md
# Ethernet Transmit Flow-Control Scheduler

This block sits between a MAC's transmit queue and its frame-level transmit engine, and it decides the cycle in which the next frame may begin. Three things can hold back data frames: a graceful-stop request from software, a software request to emit a PAUSE control frame, and a hold-off timer loaded from PAUSE frames that the receive side has decoded. Each of these takes effect only at a frame boundary. A requested control frame is still allowed out while data is held, and it takes priority over data whenever both are eligible.

The engine is driven by a one-cycle start pulse together with a kind flag (control or data). It answers with a one-cycle done pulse, or with an abort pulse when an early collision ends the frame and the frame must be retried. After each successful frame the block can also run a heartbeat check, which looks for the collision input during a short window. Carrier and collision gate frame starts only in half-duplex mode. The duplex mode and the heartbeat enable are taken into the block only while the MAC is disabled.

Top module: `tx_flow_sched`

## Requirements
- R1: While `gstop_req_i` is high, a data frame already in flight runs to its done pulse, and no new data frame is started.
- R2: When transmission is halted (by `gstop_req_i` or by a pending PAUSE request) and no frame is in flight, `gstop_ack_o` pulses high for exactly one cycle. This happens the cycle after the halt is seen while idle, or the cycle after the in-flight frame's done or abort. There is one pulse per halt episode, and it re-arms only after the halt condition goes away.
- R3: Once `gstop_req_i` falls, pending data frames start again; the first starts on the next cycle in which the other start conditions hold.
- R4: If a data frame ends with `tx_abort_i` while `gstop_req_i` is high, the frame is not restarted until `gstop_req_i` falls. It is then started again as a data frame.
- R5: A one-cycle `pause_req_set_i` sets `pause_req_o`. While that bit is set, the next start is a control frame (`tx_ctrl_o` = 1), ahead of any pending data. The bit clears on that control frame's done pulse. An abort of the control frame leaves the bit set and the control frame is retried.
- R6: A requested control frame is started even while data frames are held off by `gstop_req_i` or by `rx_paused_o`.
- R7: In full duplex, `rx_pause_vld_i` loads a hold-off of `rx_pause_quanta_i` × SLOT_CYCLES cycles. During that time `rx_paused_o` is high, counting from the cycle after the load, and no data frame starts. A new load replaces the remaining time. A value of 0 clears `rx_paused_o` on the next cycle. In half duplex, loads are ignored.
- R8: In half duplex, a frame starts only in a cycle where `crs_i` and `col_i` are both low. In full duplex these inputs have no effect on starts.
- R9: With the heartbeat check enabled, every done pulse opens a window of HB_WINDOW cycles, starting the cycle after the done pulse is sampled. If `col_i` is never high in that window, `hb_err_o` sets. It stays set until the MAC is disabled.
- R10: `fdx_en_i` and `hb_en_i` are taken in only while `mac_en_i` is low. Changes made while it is high have no effect.
- R11: No frame is started while `mac_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mac_en_i | input | 1 | MAC enable; configuration is sampled while low |
| fdx_en_i | input | 1 | Full-duplex mode request |
| hb_en_i | input | 1 | Heartbeat check enable request |
| gstop_req_i | input | 1 | Graceful stop request (level) |
| pause_req_set_i | input | 1 | One-cycle request to send a PAUSE control frame |
| data_pend_i | input | 1 | A data frame is waiting in the transmit queue |
| crs_i | input | 1 | Carrier sense |
| col_i | input | 1 | Collision |
| rx_pause_vld_i | input | 1 | Received PAUSE value is valid this cycle |
| rx_pause_quanta_i | input | QUANTA_W | Received pause duration in quanta |
| tx_done_i | input | 1 | Engine finished the current frame |
| tx_abort_i | input | 1 | Current frame ended by early collision, retry needed |
| tx_start_o | output | 1 | One-cycle frame start command |
| tx_ctrl_o | output | 1 | Kind of the started frame: 1 control, 0 data |
| pause_req_o | output | 1 | PAUSE request pending, self-clearing |
| gstop_ack_o | output | 1 | One-cycle halt acknowledge |
| rx_paused_o | output | 1 | Transmitter held off by a received PAUSE |
| hb_err_o | output | 1 | Sticky heartbeat error |

## Verification
The assertions assume the engine follows the handshake. It raises done or abort only while a frame it was told to start is in flight, never in the same cycle as the start, and never both at once. `pause_req_set_i` and `rx_pause_vld_i` are assumed to be single-cycle pulses. The bench's engine model keeps to this: it counts a fixed frame length from each observed start and returns exactly one completion pulse. All stimulus changes on the falling clock edge, with request pulses held for one cycle.

// File: rtl/tx_fc_pkg.sv
package tx_fc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_CTRL = 2'd2
  } tx_state_e;
endpackage

// File: rtl/tx_fc_rx_pause.sv
module tx_fc_rx_pause #(
  parameter int QUANTA_W    = 16,
  parameter int SLOT_CYCLES = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_en_i,
  input  logic                load_i,
  input  logic [QUANTA_W-1:0] quanta_i,
  output logic                paused_o
);
  localparam int SW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_CYCLES - 1);

  logic [QUANTA_W-1:0] q_cnt;
  logic [SW-1:0]       s_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_cnt <= '0;
      s_cnt <= '0;
    end else if (load_i && load_en_i) begin
      q_cnt <= quanta_i;
      s_cnt <= SLOT_LAST;
    end else if (q_cnt != '0) begin
      if (s_cnt == '0) begin
        s_cnt <= SLOT_LAST;
        q_cnt <= q_cnt - 1'b1;
      end else begin
        s_cnt <= s_cnt - 1'b1;
      end
    end
  end

  assign paused_o = (q_cnt != '0);
endmodule

// File: rtl/tx_fc_heartbeat.sv
module tx_fc_heartbeat #(
  parameter int HB_WINDOW = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic clear_i,
  input  logic frame_end_i,
  input  logic col_i,
  output logic err_o
);
  localparam int HW = $clog2(HB_WINDOW + 1);

  logic [HW-1:0] win_cnt;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt <= '0;
      seen_q  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      if (clear_i) err_o <= 1'b0;
      if (frame_end_i && enable_i) begin
        win_cnt <= HW'(HB_WINDOW);
        seen_q  <= 1'b0;
      end else if (win_cnt != '0) begin
        win_cnt <= win_cnt - 1'b1;
        if (col_i) seen_q <= 1'b1;
        // last window cycle without any collision seen
        if (win_cnt == HW'(1) && !seen_q && !col_i && !clear_i) err_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tx_fc_sched.sv
module tx_fc_sched
  import tx_fc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mac_en_i,
  input  logic fdx_i,
  input  logic gstop_req_i,
  input  logic pause_set_i,
  input  logic data_pend_i,
  input  logic crs_i,
  input  logic col_i,
  input  logic rx_paused_i,
  input  logic tx_done_i,
  input  logic tx_abort_i,
  output logic tx_start_o,
  output logic tx_ctrl_o,
  output logic pause_req_o,
  output logic gstop_ack_o
);
  tx_state_e state_q, state_d;
  logic pause_req_q, acked_q;
  logic idle, carrier_ok, can_go, go_ctrl, go_data, halt, stop_now, frame_end;

  assign idle       = (state_q == ST_IDLE);
  assign carrier_ok = fdx_i | (~crs_i & ~col_i);
  assign can_go     = mac_en_i & idle & carrier_ok;
  assign go_ctrl    = can_go & pause_req_q;
  assign go_data    = can_go & ~pause_req_q & ~gstop_req_i & ~rx_paused_i & data_pend_i;
  assign halt       = gstop_req_i | pause_req_q;
  assign stop_now   = halt & idle & ~acked_q;
  assign frame_end  = tx_done_i | tx_abort_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (go_ctrl)      state_d = ST_CTRL;
        else if (go_data) state_d = ST_DATA;
      end
      ST_DATA, ST_CTRL: if (frame_end) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pause_req_q <= 1'b0;
      acked_q     <= 1'b0;
      gstop_ack_o <= 1'b0;
      tx_start_o  <= 1'b0;
      tx_ctrl_o   <= 1'b0;
    end else begin
      state_q     <= state_d;
      gstop_ack_o <= stop_now;
      acked_q     <= halt & (acked_q | stop_now);
      tx_start_o  <= go_ctrl | go_data;
      if (go_ctrl)      tx_ctrl_o <= 1'b1;
      else if (go_data) tx_ctrl_o <= 1'b0;
      // a new request wins over completion of the previous control frame
      if (pause_set_i)                               pause_req_q <= 1'b1;
      else if (state_q == ST_CTRL && tx_done_i)      pause_req_q <= 1'b0;
    end
  end

  assign pause_req_o = pause_req_q;
endmodule

// File: rtl/tx_flow_sched.sv
module tx_flow_sched #(
  parameter int QUANTA_W    = 16,
  parameter int SLOT_CYCLES = 8,
  parameter int HB_WINDOW   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mac_en_i,
  input  logic                fdx_en_i,
  input  logic                hb_en_i,
  input  logic                gstop_req_i,
  input  logic                pause_req_set_i,
  input  logic                data_pend_i,
  input  logic                crs_i,
  input  logic                col_i,
  input  logic                rx_pause_vld_i,
  input  logic [QUANTA_W-1:0] rx_pause_quanta_i,
  input  logic                tx_done_i,
  input  logic                tx_abort_i,
  output logic                tx_start_o,
  output logic                tx_ctrl_o,
  output logic                pause_req_o,
  output logic                gstop_ack_o,
  output logic                rx_paused_o,
  output logic                hb_err_o
);
  logic fdx_q, hb_en_q;

  // mode bits follow software only while the MAC is off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fdx_q   <= 1'b0;
      hb_en_q <= 1'b0;
    end else if (!mac_en_i) begin
      fdx_q   <= fdx_en_i;
      hb_en_q <= hb_en_i;
    end
  end

  tx_fc_rx_pause #(
    .QUANTA_W   (QUANTA_W),
    .SLOT_CYCLES(SLOT_CYCLES)
  ) u_rx_pause (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_en_i(fdx_q),
    .load_i   (rx_pause_vld_i),
    .quanta_i (rx_pause_quanta_i),
    .paused_o (rx_paused_o)
  );

  tx_fc_sched u_sched (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mac_en_i   (mac_en_i),
    .fdx_i      (fdx_q),
    .gstop_req_i(gstop_req_i),
    .pause_set_i(pause_req_set_i),
    .data_pend_i(data_pend_i),
    .crs_i      (crs_i),
    .col_i      (col_i),
    .rx_paused_i(rx_paused_o),
    .tx_done_i  (tx_done_i),
    .tx_abort_i (tx_abort_i),
    .tx_start_o (tx_start_o),
    .tx_ctrl_o  (tx_ctrl_o),
    .pause_req_o(pause_req_o),
    .gstop_ack_o(gstop_ack_o)
  );

  tx_fc_heartbeat #(
    .HB_WINDOW(HB_WINDOW)
  ) u_hb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (hb_en_q),
    .clear_i    (~mac_en_i),
    .frame_end_i(tx_done_i),
    .col_i      (col_i),
    .err_o      (hb_err_o)
  );
endmodule

// File: rtl/tx_flow_sched_chk.sv
module tx_flow_sched_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mac_en_i,
  input logic gstop_req_i,
  input logic crs_i,
  input logic col_i,
  input logic tx_done_i,
  input logic tx_start_o,
  input logic tx_ctrl_o,
  input logic pause_req_o,
  input logic gstop_ack_o,
  input logic rx_paused_o,
  input logic hb_err_o,
  input logic fdx_q
);
  AST_DATA_NOT_IN_GSTOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_start_o && !tx_ctrl_o) |-> $past(!gstop_req_i)); // R1
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gstop_ack_o |=> !gstop_ack_o); // R2
  AST_PREQ_CLEARS_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pause_req_o) |-> $past(tx_done_i)); // R5
  AST_RXP_BLOCKS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_start_o && !tx_ctrl_o) |-> $past(!rx_paused_o)); // R7
  AST_HDX_CARRIER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(fdx_q || (!crs_i && !col_i))); // R8
  AST_HB_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hb_err_o) |-> $past(!mac_en_i)); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_en_i && $past(mac_en_i)) |-> $stable(fdx_q)); // R10
  AST_MAC_EN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(mac_en_i)); // R11
endmodule

bind tx_flow_sched tx_flow_sched_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mac_en_i   (mac_en_i),
  .gstop_req_i(gstop_req_i),
  .crs_i      (crs_i),
  .col_i      (col_i),
  .tx_done_i  (tx_done_i),
  .tx_start_o (tx_start_o),
  .tx_ctrl_o  (tx_ctrl_o),
  .pause_req_o(pause_req_o),
  .gstop_ack_o(gstop_ack_o),
  .rx_paused_o(rx_paused_o),
  .hb_err_o   (hb_err_o),
  .fdx_q      (fdx_q)
);

// File: tb/tx_flow_sched_bench.sv
`timescale 1ns/1ps
module tx_flow_sched_bench;
  localparam int QW   = 16;
  localparam int SLOT = 8;
  localparam int HBW  = 4;
  localparam int LEN  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mac_en = 1'b0, fdx_en = 1'b0, hb_en = 1'b0, gstop = 1'b0, preq_set = 1'b0;
  logic crs = 1'b0, col = 1'b0, rxp_vld = 1'b0;
  logic [QW-1:0] rxp_q = '0;
  logic tx_done, tx_abort, data_pend;
  logic tx_start, tx_ctrl, pause_req, gstop_ack, rx_paused, hb_err;

  int queue_req = 0;
  int done_n, data_n, ctrl_n, ack_n, eng_cnt;
  bit cur_ctrl;
  bit abort_mode = 1'b0;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign data_pend = (queue_req > done_n);

  tx_flow_sched #(.QUANTA_W(QW), .SLOT_CYCLES(SLOT), .HB_WINDOW(HBW)) u_tx_flow_sched (
    .clk_i(clk), .rst_ni(rst_n), .mac_en_i(mac_en), .fdx_en_i(fdx_en), .hb_en_i(hb_en),
    .gstop_req_i(gstop), .pause_req_set_i(preq_set), .data_pend_i(data_pend),
    .crs_i(crs), .col_i(col), .rx_pause_vld_i(rxp_vld), .rx_pause_quanta_i(rxp_q),
    .tx_done_i(tx_done), .tx_abort_i(tx_abort), .tx_start_o(tx_start), .tx_ctrl_o(tx_ctrl),
    .pause_req_o(pause_req), .gstop_ack_o(gstop_ack), .rx_paused_o(rx_paused), .hb_err_o(hb_err)
  );

  // frame engine model and event counters
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_done <= 1'b0; tx_abort <= 1'b0; eng_cnt <= 0; cur_ctrl <= 1'b0;
      done_n <= 0; data_n <= 0; ctrl_n <= 0; ack_n <= 0;
    end else begin
      tx_done <= 1'b0; tx_abort <= 1'b0;
      if (gstop_ack) ack_n <= ack_n + 1;
      if (tx_start) begin
        eng_cnt <= LEN; cur_ctrl <= tx_ctrl;
        if (tx_ctrl) ctrl_n <= ctrl_n + 1; else data_n <= data_n + 1;
      end else if (eng_cnt != 0) begin
        eng_cnt <= eng_cnt - 1;
        if (eng_cnt == 1) begin
          if (abort_mode) tx_abort <= 1'b1;
          else begin
            tx_done <= 1'b1;
            if (!cur_ctrl) done_n <= done_n + 1;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic f, input logic h);
    mac_en = 1'b0; fdx_en = f; hb_en = h;
    step(2);
    mac_en = 1'b1;
    step(1);
  endtask

  task automatic drain();
    for (int i = 0; i < 300; i++) begin
      if (queue_req == done_n && eng_cnt == 0 && !pause_req) break;
      step(1);
    end
    step(3);
  endtask

  task automatic load_pause(input int q);
    rxp_vld = 1'b1; rxp_q = QW'(q);
    step(1);
    rxp_vld = 1'b0;
  endtask

  function automatic int measure_dummy(input int x);
    return x;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int b_data, b_ctrl, b_ack, b_done, cnt;
    step(3);
    rst_n = 1'b1;
    step(1);
    // reset state
    chk(!tx_start && !pause_req && !gstop_ack && !rx_paused && !hb_err, "R2 reset",
        {tx_start, pause_req, gstop_ack, rx_paused, hb_err}, 0);

    // R11: no starts while disabled
    queue_req++;
    step(10);
    chk(data_n == 0, "R11 disabled", data_n, 0);
    mac_en = 1'b1;
    step(5);
    chk(data_n == 1, "R11 enabled", data_n, 1);
    drain();

    // R8: half duplex waits for carrier and collision
    cfg(1'b0, 1'b0);
    crs = 1'b1; b_data = data_n; queue_req++;
    step(10);
    chk(data_n == b_data, "R8 crs holds", data_n, b_data);
    crs = 1'b0; col = 1'b1;
    step(10);
    chk(data_n == b_data, "R8 col holds", data_n, b_data);
    col = 1'b0;
    step(3);
    chk(data_n == b_data + 1, "R8 line free", data_n, b_data + 1);
    drain();

    // R10: duplex change while enabled ignored
    fdx_en = 1'b1; crs = 1'b1; b_data = data_n; queue_req++;
    step(10);
    chk(data_n == b_data, "R10 fdx ignored while enabled", data_n, b_data);
    cfg(1'b1, 1'b0);
    step(5);
    chk(data_n == b_data + 1, "R8 full duplex ignores crs", data_n, b_data + 1);
    crs = 1'b0;
    drain();

    // R1/R2/R3: graceful stop mid-frame
    b_data = data_n; b_ack = ack_n; b_done = done_n;
    queue_req += 3;
    for (int i = 0; i < 20 && data_n == b_data; i++) step(1);
    gstop = 1'b1;
    step(30);
    chk(data_n == b_data + 1, "R1 no new start", data_n, b_data + 1);
    chk(done_n == b_done + 1, "R1 in-flight completes", done_n, b_done + 1);
    chk(ack_n == b_ack + 1, "R2 ack after frame", ack_n, b_ack + 1);
    gstop = 1'b0;
    step(40);
    chk(data_n == b_data + 3, "R3 resume", data_n, b_data + 3);
    drain();

    // R2: immediate acknowledge while idle
    gstop = 1'b1;
    step(1);
    chk(gstop_ack == 1'b1, "R2 immediate ack", gstop_ack, 1);
    step(1);
    chk(gstop_ack == 1'b0, "R2 one cycle", gstop_ack, 0);
    b_ack = ack_n;
    step(5);
    chk(ack_n == b_ack, "R2 single per episode", ack_n, b_ack);
    gstop = 1'b0;
    step(2);

    // R4: early collision during graceful stop
    b_data = data_n; b_ack = ack_n; abort_mode = 1'b1;
    queue_req++;
    for (int i = 0; i < 20 && data_n == b_data; i++) step(1);
    gstop = 1'b1;
    step(25);
    chk(data_n == b_data + 1, "R4 no retry under stop", data_n, b_data + 1);
    chk(ack_n == b_ack + 1, "R4 ack after abort", ack_n, b_ack + 1);
    abort_mode = 1'b0; gstop = 1'b0;
    step(15);
    chk(data_n == b_data + 2 && queue_req == done_n, "R4 retry after clear", data_n, b_data + 2);
    drain();

    // R5: control frame first, request self-clears
    b_data = data_n; b_ctrl = ctrl_n;
    preq_set = 1'b1;
    step(1);
    preq_set = 1'b0; queue_req += 2;
    chk(pause_req == 1'b1, "R5 request set", pause_req, 1);
    step(1);
    chk(tx_start && tx_ctrl, "R5 control first", {tx_start, tx_ctrl}, 3);
    step(40);
    chk(ctrl_n == b_ctrl + 1 && pause_req == 1'b0, "R5 request cleared", ctrl_n, b_ctrl + 1);
    chk(data_n == b_data + 2, "R5 data resumes", data_n, b_data + 2);
    drain();

    // R5: aborted control frame is retried
    b_ctrl = ctrl_n; abort_mode = 1'b1;
    preq_set = 1'b1;
    step(1);
    preq_set = 1'b0;
    for (int i = 0; i < 30 && !tx_abort; i++) step(1);
    abort_mode = 1'b0;
    chk(pause_req == 1'b1, "R5 kept after abort", pause_req, 1);
    step(20);
    chk(ctrl_n == b_ctrl + 2 && !pause_req, "R5 control retried", ctrl_n, b_ctrl + 2);
    drain();

    // R6: control frame while graceful stop holds data
    gstop = 1'b1;
    step(2);
    b_data = data_n; b_ctrl = ctrl_n; queue_req++;
    preq_set = 1'b1;
    step(1);
    preq_set = 1'b0;
    step(20);
    chk(ctrl_n == b_ctrl + 1 && data_n == b_data, "R6 ctrl under stop", ctrl_n, b_ctrl + 1);
    gstop = 1'b0;
    step(20);
    chk(data_n == b_data + 1, "R6 data after stop", data_n, b_data + 1);
    drain();

    // R6/R7: control frame under received pause, data held until expiry
    b_data = data_n; b_ctrl = ctrl_n;
    load_pause(10);
    queue_req++;
    preq_set = 1'b1;
    step(1);
    preq_set = 1'b0;
    step(20);
    chk(ctrl_n == b_ctrl + 1 && data_n == b_data, "R6 ctrl under rx pause", ctrl_n, b_ctrl + 1);
    for (int i = 0; i < 200 && rx_paused; i++) step(1);
    step(3);
    chk(data_n == b_data + 1, "R7 data after pause", data_n, b_data + 1);
    drain();

    // R7: duration sweep
    for (int q = 1; q <= 4; q++) begin
      load_pause(q);
      cnt = 0;
      for (int i = 0; i < 100 && rx_paused; i++) begin cnt++; step(1); end
      chk(cnt == q * SLOT, "R7 duration", cnt, q * SLOT);
    end
    // R7: reload replaces remaining time
    load_pause(4);
    step(5);
    load_pause(1);
    cnt = 0;
    for (int i = 0; i < 100 && rx_paused; i++) begin cnt++; step(1); end
    chk(cnt == SLOT, "R7 reload", cnt, SLOT);
    // R7: zero ends pause
    load_pause(3);
    step(3);
    load_pause(0);
    chk(rx_paused == 1'b0, "R7 zero clears", rx_paused, 0);
    // R7: half duplex ignores loads
    cfg(1'b0, 1'b0);
    load_pause(5);
    chk(rx_paused == 1'b0, "R7 half duplex ignored", rx_paused, 0);

    // R9: heartbeat window sweep
    cfg(1'b1, 1'b1);
    for (int k = 1; k <= HBW + 1; k++) begin
      mac_en = 1'b0;
      step(2);
      mac_en = 1'b1;
      step(1);
      chk(hb_err == 1'b0, "R9 cleared by disable", hb_err, 0);
      queue_req++;
      for (int i = 0; i < 30 && !tx_done; i++) step(1);
      repeat (k) step(1);
      col = 1'b1;
      step(1);
      col = 1'b0;
      step(HBW + 2);
      chk(hb_err == (k > HBW), "R9 window", hb_err, int'(k > HBW));
      drain();
    end
    b_data = measure_dummy(0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule